// File: doc/BRIEF.md
# Processor Bus Command Controller

This block turns the three-bit status code that a processor drives at the start of each bus cycle into the strobes and data-path controls the rest of the bus needs. The strobes are memory read, memory write, early memory write, I/O read, I/O write, early I/O write and interrupt acknowledge. The controls are an address latch pulse, a data-transceiver enable, a transfer direction, and one output whose meaning follows a mode strap. A cycle starts when the status leaves the passive code. The block walks a short phase sequence, and the strobes come back high when the status returns to passive.

The mode strap selects one of two gating schemes. In shared system-bus mode, every command waits until the arbitration input `addr_en_n` has been low for a programmable number of clocks. In dedicated I/O-bus mode, I/O-class commands ignore arbitration, while memory commands still wait. Tri-state drivers are modelled as two output-enable flags, one for the memory commands and one for the I/O-class commands. A command-enable input can silence every strobe and both data enables at once.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: The code is latched from `stat[2:0]` when a cycle starts. The strobes it selects are: 000 interrupt acknowledge; 001 I/O read; 010 I/O write and early I/O write; 100 and 101 memory read; 110 memory write and early memory write. Codes 011 (halt) and 111 (passive) select no strobe. Every strobe is active low, and no more than two are ever low at the same time.
- R2: While the status is 111, no cycle runs. All strobes are high, `ale` is 0 and `den` is 0.
- R3: The cycle starts on the first clock edge that samples a non-passive code, and `ale` is high for exactly that one clock. Read strobes and early-write strobes go low from the second clock. Normal write strobes go low from the third clock. All strobes go high at the first edge that samples 111.
- R4: With `addr_en_n` high, the cycle counter of `addr_en_n` is cleared. A command gated by arbitration becomes active only after `addr_en_n` has been sampled low on AEN_DLY edges (default 2). In system-bus mode (`io_mode`=0) this gate covers every command. In I/O-bus mode it covers only the memory commands.
- R5: When `addr_en_n` is high, `mem_oe` is 0 in the same cycle and the memory strobes are high. In system-bus mode, `io_oe` is also 0 and the I/O-class strobes are high.
- R6: With `io_mode`=1, `io_oe` is 1. The I/O read, I/O write, early I/O write and interrupt acknowledge strobes then follow R3 whatever the value of `addr_en_n`.
- R7: While `cmd_en` is 0, all strobes are high, `den` is 0, and the peripheral data enable is inactive (`cas_pden`=1 when `io_mode`=1). This takes effect in the same cycle.
- R8: `dir_tx` is 1 throughout a cycle with code 010 or 110. It is 0 for any other code and when no cycle is running.
- R9: With `io_mode`=0, `cas_pden` is an active-high cascade enable, high throughout a code 000 cycle. With `io_mode`=1, it is an active-low peripheral data enable, low from the second clock of a cycle with code 000, 001 or 010.
- R10: `den` is high from the second clock of a cycle that moves data (any code except 011). In I/O-bus mode, `den` stays low for codes 000, 001 and 010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat | input | 3 | Processor status code |
| io_mode | input | 1 | Mode strap: 1 selects dedicated I/O bus, 0 selects shared system bus |
| addr_en_n | input | 1 | Bus granted by arbitration, active low |
| cmd_en | input | 1 | Command enable; 0 forces strobes and data enables inactive |
| ale | output | 1 | Address latch pulse, active high |
| den | output | 1 | Data transceiver enable, active high |
| dir_tx | output | 1 | Transfer direction: 1 transmit (write), 0 receive |
| cas_pden | output | 1 | Cascade enable (io_mode=0) or peripheral data enable, active low (io_mode=1) |
| mem_oe | output | 1 | Driver enable for the memory strobes |
| io_oe | output | 1 | Driver enable for the I/O-class strobes |
| mem_rd_n | output | 1 | Memory read strobe |
| mem_wr_n | output | 1 | Memory write strobe |
| mem_wr_early_n | output | 1 | Early memory write strobe |
| io_rd_n | output | 1 | I/O read strobe |
| io_wr_n | output | 1 | I/O write strobe |
| io_wr_early_n | output | 1 | Early I/O write strobe |
| int_ack_n | output | 1 | Interrupt acknowledge strobe |

## Verification
A latched code that is wrong shows up one clock after `ale`, as the wrong strobe pair or a wrong `dir_tx` level. A phase counter that is out of step shows as a write strobe landing together with its early partner, or as `ale` lasting two clocks. A fault in the arbitration counter moves the first low strobe off the AEN_DLY-th edge. It can also leave `mem_oe` set in the same cycle that `addr_en_n` rises, so every such fault reaches the ports within the cycle concerned.

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl #(
  parameter int AEN_DLY = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] stat,
  input  logic       io_mode,
  input  logic       addr_en_n,
  input  logic       cmd_en,
  output logic       ale,
  output logic       den,
  output logic       dir_tx,
  output logic       cas_pden,
  output logic       mem_oe,
  output logic       io_oe,
  output logic       mem_rd_n,
  output logic       mem_wr_n,
  output logic       mem_wr_early_n,
  output logic       io_rd_n,
  output logic       io_wr_n,
  output logic       io_wr_early_n,
  output logic       int_ack_n
);
  localparam int CW = $clog2(AEN_DLY + 2);
  localparam logic [CW-1:0] CNT_DONE = CW'(AEN_DLY);
  localparam logic [2:0] C_INTA = 3'b000, C_IORD = 3'b001, C_IOWR = 3'b010, C_HALT = 3'b011;
  localparam logic [2:0] C_CODE = 3'b100, C_MRD = 3'b101, C_MWR = 3'b110, C_IDLE = 3'b111;

  logic [1:0]    phase;
  logic [2:0]    code_q;
  logic [CW-1:0] aen_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= 2'd0;
      code_q <= C_IDLE;
    end else if (stat == C_IDLE) begin
      phase  <= 2'd0;
    end else if (phase == 2'd0) begin
      phase  <= 2'd1;
      code_q <= stat;
    end else if (phase != 2'd3) begin
      phase  <= phase + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                aen_cnt <= '0;
    else if (addr_en_n)        aen_cnt <= '0;
    else if (aen_cnt != CNT_DONE) aen_cnt <= aen_cnt + 1'b1;
  end

  logic aen_ok, busy, early, late;
  logic is_inta, is_iord, is_iowr, is_mrd, is_mwr, io_cls, mem_go, io_go, pden_act;

  assign aen_ok  = !addr_en_n && (aen_cnt == CNT_DONE);
  assign busy    = (phase != 2'd0);
  assign early   = phase[1];
  assign late    = (phase == 2'd3);

  assign is_inta = busy && code_q == C_INTA;
  assign is_iord = busy && code_q == C_IORD;
  assign is_iowr = busy && code_q == C_IOWR;
  assign is_mrd  = busy && (code_q == C_CODE || code_q == C_MRD);
  assign is_mwr  = busy && code_q == C_MWR;
  assign io_cls  = is_inta || is_iord || is_iowr;

  assign mem_oe  = aen_ok;
  assign io_oe   = io_mode || aen_ok;
  assign mem_go  = cmd_en && mem_oe;
  assign io_go   = cmd_en && io_oe;

  assign int_ack_n      = !(io_go && early && is_inta);
  assign io_rd_n        = !(io_go && early && is_iord);
  assign io_wr_early_n  = !(io_go && early && is_iowr);
  assign io_wr_n        = !(io_go && late  && is_iowr);
  assign mem_rd_n       = !(mem_go && early && is_mrd);
  assign mem_wr_early_n = !(mem_go && early && is_mwr);
  assign mem_wr_n       = !(mem_go && late  && is_mwr);

  assign ale      = (phase == 2'd1);
  assign dir_tx   = is_iowr || is_mwr;
  assign den      = cmd_en && early && busy && code_q != C_HALT && !(io_mode && io_cls);
  assign pden_act = cmd_en && early && io_mode && io_cls;
  assign cas_pden = io_mode ? !pden_act : is_inta;
endmodule

// File: rtl/bus_cmd_ctrl_chk.sv
module bus_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] stat,
  input logic       io_mode,
  input logic       addr_en_n,
  input logic       cmd_en,
  input logic       ale,
  input logic       den,
  input logic       dir_tx,
  input logic       mem_oe,
  input logic       io_oe,
  input logic [6:0] strb
);
  // strb order: int_ack, io_rd, io_wr, io_wr_early, mem_rd, mem_wr, mem_wr_early

  // R1
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~strb) <= 2);

  // R2
  passive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stat == 3'b111) |-> (&strb) && !ale && !den);

  // R3
  ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R4
  aen_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_mode && $fell(addr_en_n)) |-> (&strb));

  // R5
  aen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_en_n && !io_mode) |-> !mem_oe && !io_oe && (&strb));

  // R6
  io_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_mode |-> io_oe);

  // R7
  cmd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_en |-> (&strb) && !den);

  // R8
  wr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb[4] && strb[3] && strb[1] && strb[0]) |-> dir_tx);
endmodule

bind bus_cmd_ctrl bus_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stat(stat), .io_mode(io_mode),
  .addr_en_n(addr_en_n), .cmd_en(cmd_en), .ale(ale), .den(den),
  .dir_tx(dir_tx), .mem_oe(mem_oe), .io_oe(io_oe),
  .strb({int_ack_n, io_rd_n, io_wr_n, io_wr_early_n, mem_rd_n, mem_wr_n, mem_wr_early_n})
);

// File: tb/tb_bus_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_bus_cmd_ctrl;
  logic clk = 0, rst_n = 0;
  logic [2:0] stat = 3'b111;
  logic io_mode = 0, addr_en_n = 1, cmd_en = 1;
  logic ale, den, dir_tx, cas_pden, mem_oe, io_oe;
  logic mem_rd_n, mem_wr_n, mem_wr_early_n, io_rd_n, io_wr_n, io_wr_early_n, int_ack_n;
  logic [6:0] strb;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  bus_cmd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .stat(stat), .io_mode(io_mode), .addr_en_n(addr_en_n),
    .cmd_en(cmd_en), .ale(ale), .den(den), .dir_tx(dir_tx), .cas_pden(cas_pden),
    .mem_oe(mem_oe), .io_oe(io_oe), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_wr_early_n(mem_wr_early_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .io_wr_early_n(io_wr_early_n), .int_ack_n(int_ack_n)
  );

  assign strb = {int_ack_n, io_rd_n, io_wr_n, io_wr_early_n, mem_rd_n, mem_wr_n, mem_wr_early_n};

  // {io_mode, code, strb at third clock, den, dir_tx, cas_pden}
  localparam logic [13:0] VEC [16] = '{
    14'b0_000_0111111_1_0_1, 14'b0_001_1011111_1_0_0,
    14'b0_010_1100111_1_1_0, 14'b0_011_1111111_0_0_0,
    14'b0_100_1111011_1_0_0, 14'b0_101_1111011_1_0_0,
    14'b0_110_1111100_1_1_0, 14'b0_111_1111111_0_0_0,
    14'b1_000_0111111_0_0_0, 14'b1_001_1011111_0_0_0,
    14'b1_010_1100111_0_1_0, 14'b1_011_1111111_0_0_1,
    14'b1_100_1111011_1_0_1, 14'b1_101_1111011_1_0_1,
    14'b1_110_1111100_1_1_1, 14'b1_111_1111111_0_0_1
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    check("R2 reset strobes", 32'(strb), 32'h7f);
    check("R2 reset ale/den", {ale, den}, 2'b00);
    check("R5 reset mem_oe", 32'(mem_oe), 0);
    rst_n = 1;
    addr_en_n = 0;
    repeat (3) tick();

    for (int i = 0; i < 16; i++) begin
      io_mode = VEC[i][13];
      stat = VEC[i][12:10];
      tick();
      check("R3 ale first clock", 32'(ale), 32'(VEC[i][12:10] != 3'b111));
      tick(); tick();
      check("R1 decode strobes", 32'(strb), 32'(VEC[i][9:3]));
      check("R10 den", 32'(den), 32'(VEC[i][2]));
      check("R8 dir_tx", 32'(dir_tx), 32'(VEC[i][1]));
      check("R9 cas_pden", 32'(cas_pden), 32'(VEC[i][0]));
      stat = 3'b111;
      tick();
      check("R3 release on passive", {strb, ale}, 8'hfe);
    end

    // R3 phase timing of a memory write in system-bus mode
    io_mode = 0;
    stat = 3'b110;
    tick();
    check("R3 write clk1", {strb, ale}, 8'hff);
    tick();
    check("R3 write clk2 early only", {strb, ale}, {7'b1111110, 1'b0});
    tick();
    check("R3 write clk3 both", 32'(strb), 32'b1111100);
    stat = 3'b111;
    tick();

    // R4 arbitration wait, R5 immediate release
    addr_en_n = 1;
    stat = 3'b101;
    repeat (3) tick();
    check("R4 no grant strobes", 32'(strb), 32'h7f);
    check("R5 no grant mem_oe", 32'(mem_oe), 0);
    addr_en_n = 0;
    tick();
    check("R4 one edge not enough", 32'(strb), 32'h7f);
    tick();
    check("R4 read after delay", 32'(strb), 32'b1111011);
    check("R4 mem_oe after delay", 32'(mem_oe), 1);
    addr_en_n = 1;
    #1;
    check("R5 immediate release", {strb, mem_oe, io_oe}, {7'h7f, 2'b00});
    stat = 3'b111;
    tick();

    // R6 I/O bus mode bypasses arbitration for I/O only
    io_mode = 1;
    stat = 3'b001;
    tick(); tick();
    check("R6 io read w/o grant", 32'(strb), 32'b1011111);
    check("R6 oe flags", {io_oe, mem_oe}, 2'b10);
    stat = 3'b111;
    tick();
    stat = 3'b101;
    tick(); tick();
    check("R4 mem still gated in io mode", 32'(strb), 32'h7f);
    stat = 3'b111;
    tick();

    // R7 command enable in I/O bus mode
    stat = 3'b010;
    repeat (3) tick();
    check("R9 pden active", 32'(cas_pden), 0);
    cmd_en = 0;
    #1;
    check("R7 strobes forced off", 32'(strb), 32'h7f);
    check("R7 pden forced off", {den, cas_pden}, 2'b01);
    cmd_en = 1;
    #1;
    check("R7 strobes back", 32'(strb), 32'b1100111);
    stat = 3'b111;
    tick();

    // R7 command enable forces den low in system-bus mode
    io_mode = 0;
    addr_en_n = 0;
    tick(); tick();
    stat = 3'b101;
    repeat (3) tick();
    check("R10 den on", 32'(den), 1);
    cmd_en = 0;
    #1;
    check("R7 den forced off", {den, mem_rd_n}, 2'b01);
    cmd_en = 1;
    stat = 3'b111;
    tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule